// File: doc/BRIEF.md
# Two-Wire Bus Join Controller

This block decides when the upstream and downstream segments of a two-wire bus buffer may be tied together. It watches the clock and data lines of both segments and keeps them apart until neither side is in the middle of a transfer. Before joining, each segment must either have stayed quiet for a programmable idle time or have just finished a transfer with a STOP. The analog pass devices and level translation sit outside the block. They follow the `link` output.

The same decision is made again after every break. A break can come from the enable input dropping or from a stuck-bus fault reported by a separate recovery sequencer. While that sequencer is clocking the bus free, the block holds the segments apart and keeps the rise-time accelerators off. Once it has finished, the block rejoins as soon as the idle-or-STOP agreement holds. A fresh rising edge on the enable input after a fault forces an immediate join, even on a bus that is still held low. The ready status is brought out as a level and as an open-drain style pull-down request.

Top module: `bus_join_ctrl`

## Requirements
- R1: After reset the segments are apart: `link`, `rdy` and `acc_en` are 0 and `rdy_pd` is 1, and bus activity cannot produce a join until the idle-or-STOP rule below is met.
- R2: A segment counts as idle once both of its lines have been sampled high on IDLE_CYC consecutive clock edges. With both segments idle, `link` rises one clock later.
- R3: A STOP is seen on a segment when SDA is sampled rising from 0 to 1 while SCL is high on both samples. A STOP on one segment while the other is idle joins on the next clock edge, even if the STOP segment has not yet been idle.
- R4: Any line low on a segment restarts that segment's idle count. This includes a START, which is SDA falling while SCL is high. While one segment is busy and shows no STOP, there is no join even if the other segment is idle.
- R5: `en` low drops `link` and `acc_en` in the same cycle, and `rdy` goes to 0 with `rdy_pd` at 1.
- R6: When `en` returns high with no fault pending, the block waits for the idle-or-STOP rule again before joining.
- R7: `flt_req` high drops `link` in the same cycle and keeps it low on the next cycle. After the fault, the segments rejoin automatically once the idle-or-STOP rule holds and recovery is not active.
- R8: After a fault, a low-then-high cycle on `en` joins on the first clock edge with `en` high, without waiting for the idle-or-STOP rule.
- R9: `acc_en` is 1 only while linked and `rcv_act` is 0. While `rcv_act` is 1, the idle-or-STOP rule does not produce a join.
- R10: `rdy` is 1 exactly while the segments are linked, and `rdy_pd` is always its inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_scl | input | 1 | Upstream clock line, synchronized |
| up_sda | input | 1 | Upstream data line, synchronized |
| dn_scl | input | 1 | Downstream clock line, synchronized |
| dn_sda | input | 1 | Downstream data line, synchronized |
| en | input | 1 | Active-high join enable |
| flt_req | input | 1 | Stuck-bus disconnect request from the recovery sequencer |
| rcv_act | input | 1 | Recovery sequencer is clocking the bus or issuing its STOP |
| link | output | 1 | Join the two segments |
| rdy | output | 1 | Ready status, high while joined |
| rdy_pd | output | 1 | Pull-down request for the open-drain ready pin |
| acc_en | output | 1 | Enable for the rise-time accelerators |

## Verification
Joining is tried with both segments quiet from reset, with a STOP on the upstream side against a quiet downstream side, with a START left pending upstream, and with an upstream idle stretch broken by one low clock sample. These patterns separate an idle-only rule from the STOP path, and show whether a busy side really blocks a join. They also show whether the idle count restarts instead of accumulating across a glitch. Fault handling is tried in two ways. In the first, recovery activity delays an automatic rejoin. In the second, the bus is held busy so that only the enable edge can force the join, and a later plain enable cycle must then fall back to the normal rule.

// File: rtl/bjc_pkg.sv
package bjc_pkg;

    // number of bus segments watched: upstream (0) and downstream (1)
    localparam int unsigned SIDES = 2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // enable low
        ST_SEEK = 2'd1,   // apart, waiting for the idle-or-STOP agreement
        ST_LINK = 2'd2    // segments joined
    } join_st_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    typedef struct packed {
        logic idle;   // lines high long enough
        logic stop;   // STOP seen on this sample
    } side_view_t;

    // data rising while clock stays high across two samples
    function automatic logic stop_seen(line_pair_t prev, line_pair_t cur);
        return prev.scl & cur.scl & ~prev.sda & cur.sda;
    endfunction

    // both quiet, or one finishing with a STOP while the other is quiet
    function automatic logic join_rule(side_view_t a, side_view_t b);
        return (a.idle & b.idle) | (a.stop & b.idle) | (a.idle & b.stop);
    endfunction

endpackage

// File: rtl/bjc_side_mon.sv
module bjc_side_mon
    import bjc_pkg::*;
#(
    parameter int unsigned IDLE_CYC = 9500
) (
    input  logic       clk,
    input  logic       rst,
    input  line_pair_t lines,
    output side_view_t view
);

    localparam int unsigned CW  = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(IDLE_CYC);

    logic [CW-1:0] cnt;
    line_pair_t    prev;

    // A low on either line (a START included) clears the count.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            prev <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev <= lines;
            if (!(lines.scl && lines.sda)) begin
                cnt <= '0;
            end else if (cnt != LIM) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign view.idle = (cnt == LIM);
    assign view.stop = stop_seen(prev, lines);

endmodule

// File: rtl/bjc_link_fsm.sv
module bjc_link_fsm
    import bjc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic flt_req,
    input  logic rcv_act,
    input  logic join_ok,
    output logic link,
    output logic acc_en
);

    join_st_e st_q, st_d;
    logic     seen_q, seen_d;   // a fault broke the link and no join has followed

    always_comb begin
        st_d   = st_q;
        seen_d = seen_q;
        if (flt_req) begin
            st_d   = en ? ST_SEEK : ST_OFF;
            seen_d = 1'b1;
        end else if (!en) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    if (seen_q) begin
                        // enable edge after a fault forces the join
                        st_d   = ST_LINK;
                        seen_d = 1'b0;
                    end else begin
                        st_d = ST_SEEK;
                    end
                end
                ST_SEEK: begin
                    if (join_ok && !rcv_act) begin
                        st_d   = ST_LINK;
                        seen_d = 1'b0;
                    end
                end
                ST_LINK: st_d = ST_LINK;
                default: st_d = ST_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_SEEK;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            seen_q <= seen_d;
        end
    end

    // enable low and a fault request both break the join without waiting a clock
    assign link   = (st_q == ST_LINK) & en & ~flt_req;
    assign acc_en = link & ~rcv_act;

endmodule

// File: rtl/bus_join_ctrl.sv
module bus_join_ctrl
    import bjc_pkg::*;
#(
    parameter int unsigned IDLE_CYC = 9500
) (
    input  logic clk,
    input  logic rst,
    input  logic up_scl,
    input  logic up_sda,
    input  logic dn_scl,
    input  logic dn_sda,
    input  logic en,
    input  logic flt_req,
    input  logic rcv_act,
    output logic link,
    output logic rdy,
    output logic rdy_pd,
    output logic acc_en
);

    line_pair_t lines [SIDES];
    side_view_t views [SIDES];
    logic       join_ok;

    assign lines[0] = '{scl: up_scl, sda: up_sda};
    assign lines[1] = '{scl: dn_scl, sda: dn_sda};

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        bjc_side_mon #(.IDLE_CYC(IDLE_CYC)) u_mon (
            .clk   (clk),
            .rst   (rst),
            .lines (lines[g]),
            .view  (views[g])
        );
    end

    assign join_ok = join_rule(views[0], views[1]);

    bjc_link_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .flt_req (flt_req),
        .rcv_act (rcv_act),
        .join_ok (join_ok),
        .link    (link),
        .acc_en  (acc_en)
    );

    assign rdy    = link;
    assign rdy_pd = ~link;

endmodule

// File: rtl/bjc_chk.sv
module bjc_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic flt_req,
    input logic rcv_act,
    input logic link,
    input logic acc_en
);

    // R1
    boot_apart_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !link);

    // R5
    en_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !link);

    // R7
    flt_drop_chk: assert property (@(posedge clk) disable iff (rst)
        flt_req |=> !link);

    // R9
    acc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |-> (link && !rcv_act));

endmodule

bind bus_join_ctrl bjc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .flt_req (flt_req),
    .rcv_act (rcv_act),
    .link    (link),
    .acc_en  (acc_en)
);

// File: tb/bus_join_ctrl_bench.sv
module bus_join_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int IDLE  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_scl = 1'b1, up_sda = 1'b1, dn_scl = 1'b1, dn_sda = 1'b1;
    logic en = 1'b1, flt_req = 1'b0, rcv_act = 1'b0;
    logic link, rdy, rdy_pd, acc_en;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    bus_join_ctrl #(.IDLE_CYC(IDLE)) u_bus_join_ctrl (
        .clk(clk), .rst(rst),
        .up_scl(up_scl), .up_sda(up_sda), .dn_scl(dn_scl), .dn_sda(dn_sda),
        .en(en), .flt_req(flt_req), .rcv_act(rcv_act),
        .link(link), .rdy(rdy), .rdy_pd(rdy_pd), .acc_en(acc_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_and_idle;
        chk("R1 link after reset", link, 1'b0);
        chk("R1 rdy after reset", rdy, 1'b0);
        chk("R1 rdy_pd after reset", rdy_pd, 1'b1);
        chk("R1 acc_en after reset", acc_en, 1'b0);
        cyc(IDLE - 2);
        chk("R2 no join before idle time", link, 1'b0);
        cyc(5);
        chk("R2 join when both idle", link, 1'b1);
        chk("R10 rdy while linked", rdy, 1'b1);
        chk("R10 rdy_pd while linked", rdy_pd, 1'b0);
        chk("R9 acc_en while linked", acc_en, 1'b1);
    endtask

    task automatic t_enable_drop;
        en = 1'b0;
        #1;
        chk("R5 link drops at once", link, 1'b0);
        chk("R5 rdy low", rdy, 1'b0);
        chk("R5 rdy_pd high", rdy_pd, 1'b1);
        chk("R5 acc_en low", acc_en, 1'b0);
        cyc(1);
        chk("R5 stays apart", link, 1'b0);
    endtask

    task automatic t_start_blocks;
        up_sda = 1'b0;              // START on upstream
        cyc(2);
        en = 1'b1;
        cyc(40);
        chk("R4 pending START blocks join", link, 1'b0);
        chk("R6 enable high waits for rule", rdy_pd, 1'b1);
    endtask

    task automatic t_stop_joins;
        up_scl = 1'b0;
        cyc(3);
        up_scl = 1'b1;
        cyc(2);
        chk("R3 no join before STOP", link, 1'b0);
        up_sda = 1'b1;              // STOP
        cyc(1);
        chk("R3 STOP against idle side joins", link, 1'b1);
    endtask

    task automatic t_idle_restart;
        en = 1'b0;
        up_sda = 1'b0;
        up_scl = 1'b0;
        cyc(2);
        en = 1'b1;
        cyc(2);
        up_sda = 1'b1;              // data first: no STOP on release
        cyc(1);
        up_scl = 1'b1;
        cyc(15);
        up_scl = 1'b0;
        cyc(1);
        up_scl = 1'b1;
        cyc(IDLE - 2);
        chk("R4 low sample restarts idle count", link, 1'b0);
        cyc(5);
        chk("R2 join after restarted idle time", link, 1'b1);
    endtask

    task automatic t_fault_recover;
        flt_req = 1'b1;
        rcv_act = 1'b1;
        #1;
        chk("R7 fault drops link at once", link, 1'b0);
        chk("R9 acc_en off on fault", acc_en, 1'b0);
        cyc(1);
        chk("R7 apart after fault", link, 1'b0);
        chk("R10 rdy_pd after fault", rdy_pd, 1'b1);
        flt_req = 1'b0;
        cyc(10);
        chk("R9 recovery blocks join", link, 1'b0);
        rcv_act = 1'b0;
        cyc(1);
        chk("R7 automatic rejoin", link, 1'b1);
        chk("R9 acc_en back on", acc_en, 1'b1);
    endtask

    task automatic t_en_override;
        dn_sda = 1'b0;              // downstream held busy
        flt_req = 1'b1;
        rcv_act = 1'b1;
        cyc(1);
        flt_req = 1'b0;
        cyc(3);
        chk("R7 busy bus stays apart", link, 1'b0);
        en = 1'b0;
        cyc(2);
        en = 1'b1;
        cyc(1);
        chk("R8 enable edge forces join", link, 1'b1);
        chk("R9 acc_en off during recovery", acc_en, 1'b0);
        rcv_act = 1'b0;
        #1;
        chk("R9 acc_en on after recovery", acc_en, 1'b1);
        cyc(1);
        en = 1'b0;
        cyc(1);
        en = 1'b1;
        cyc(5);
        chk("R6 plain enable cycle needs rule", link, 1'b0);
        chk("R10 rdy low while apart", rdy, 1'b0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        t_reset_and_idle();
        t_enable_drop();
        t_start_blocks();
        t_stop_joins();
        t_idle_restart();
        t_fault_recover();
        t_en_override();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule